// File: doc/BRIEF.md
# SPI Master Controller with Word FIFOs

This block is a register-mapped SPI bus master. Software reaches it through a 32-bit register port with a byte address, a write strobe and a read strobe. Timing and word format are loaded while the block sits in its configuration mode. Switching to run mode lets the serial engine take words from a small transmit queue, shift them out on MOSI while it samples MISO, and place each received word in a receive queue.

Words are 8 or 16 bits long and go out either most significant bit first or least significant bit first. Any of the four clock polarity and phase combinations can be selected. The serial clock period is N+1 system clock cycles, with N set in software. The interrupt output rises when the receive queue holds at least a programmed number of words (1 to 4) and the interrupt is enabled. Chip selects are handled outside the block.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset the mode register reads 0x40 (configuration) and control 0 reads 0x0000. Control 1 reads 0x0108 (divider 1, 8-bit words). Status reads 0x0004. irq is low and sck is low.
- R2: A write to offset 0x00 sets the mode from bits 7:6: 01 is configuration and 10 is run. Writes that carry 00 or 11 in those bits leave the mode unchanged. Reads return the mode in bits 7:6.
- R3: A write to offset 0x00 with bit 0 set empties both queues in the next cycle.
- R4: Each queue holds 4 words. A write to offset 0x18 pushes the transmit queue, and the write is dropped when the queue is full. A read of 0x18 pops the receive queue and returns 0 when that queue is empty.
- R5: Writes to control 1 (offset 0x08), and to bits 2:0 of control 0 (offset 0x04), take effect only in configuration mode. Control 0 bits 13:12 and bit 9 accept writes in any mode.
- R6: Control 1 bits 7:0 set the word length. The value 16 selects 16-bit words and any other value selects 8-bit words. Reads return 8 or 16.
- R7: Control 1 bits 15:8 hold the divider N, and a written 0 is stored as 1. Inside a word, successive leading sck edges are N+1 clock cycles apart.
- R8: Control 0 bit 0 (polarity) sets the idle level of sck. With control 0 bit 1 (phase) at 0, data is sampled on the leading edge of each bit. With it at 1, data is sampled on the trailing edge. MISO is captured at the same edge on which a receiving slave would sample MOSI.
- R9: When control 0 bit 2 is 1, the most significant bit of a word goes out first. When it is 0, the least significant bit goes out first.
- R10: The status register at offset 0x14 reports the following. Bit 14 is the threshold flag. Bits 13:11 hold the transmit queue count. Bits 10:8 hold the receive queue count. Bit 2 is set when no word is shifting and the transmit queue is empty.
- R11: The threshold flag is set when the receive count is at least control 0 bits 13:12 plus one. irq equals this flag ANDed with control 0 bit 9.
- R12: Entering configuration mode abandons the word being shifted. sck returns to its idle level, no word is written to the receive queue, and words still queued for transmit stay queued.
- R13: In run mode, a word starts shifting as soon as the transmit queue is not empty, and queued words follow one another without any software action.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock and serial clock base |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 5 | Register byte address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rd | input | 1 | Register read strobe (pops the receive queue at offset 0x18) |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| irq | output | 1 | Receive threshold interrupt |

## Verification
On every cycle the assertions check several invariants. Queue counts never go past the depth, and a clear always empties the queues. The divider counter stays inside the programmed period. While nothing is shifting, sck sits at its polarity level. Leaving run mode stops the engine, control 1 does not change during run mode, and the interrupt never fires with an empty receive queue. Other behaviour depends on whole sequences, and only the bench scenarios can show it. These include the bit order and sample edge of each serial word (checked by a slave model on a MOSI-to-MISO loopback), the sck period for several divider values, the read-back masking of locked fields, and the threshold crossing. The bench also shows that an abandoned word leaves the queued words in place.

// File: rtl/spim_pkg.sv
`timescale 1ns/1ps
package spim_pkg;
   typedef enum logic [1:0] {
      MODE_CFG = 2'b01,
      MODE_RUN = 2'b10
   } spim_mode_e;

   localparam logic [4:0] A_MODE = 5'h00;
   localparam logic [4:0] A_CTL0 = 5'h04;
   localparam logic [4:0] A_CTL1 = 5'h08;
   localparam logic [4:0] A_STAT = 5'h14;
   localparam logic [4:0] A_DATA = 5'h18;

   localparam int WORD_W = 16;
endpackage

// File: rtl/spim_fifo.sv
`timescale 1ns/1ps
module spim_fifo #(
   parameter int W     = 16,
   parameter int DEPTH = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         clr,
   input  logic                         push,
   input  logic [W-1:0]                 din,
   input  logic                         pop,
   output logic [W-1:0]                 dout,
   output logic [$clog2(DEPTH+1)-1:0]   count,
   output logic                         empty
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] rd_ptr, wr_ptr, rd_nx, wr_nx;
   logic [CW-1:0] count_q;
   logic          full, do_push, do_pop;

   assign empty   = (count_q == '0);
   assign full    = (count_q == CW'(DEPTH));
   assign do_pop  = pop && !empty;
   assign do_push = push && (!full || do_pop);
   assign dout    = mem[rd_ptr];
   assign count   = count_q;

   generate
      if ((1 << PW) == DEPTH) begin : g_pow2
         assign rd_nx = rd_ptr + 1'b1;
         assign wr_nx = wr_ptr + 1'b1;
      end else begin : g_wrap
         assign rd_nx = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
         assign wr_nx = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (do_push && !clr) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr  <= '0;
         wr_ptr  <= '0;
         count_q <= '0;
      end else if (clr) begin
         rd_ptr  <= '0;
         wr_ptr  <= '0;
         count_q <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nx;
         if (do_pop)  rd_ptr <= rd_nx;
         case ({do_push, do_pop})
            2'b10:   count_q <= count_q + 1'b1;
            2'b01:   count_q <= count_q - 1'b1;
            default: count_q <= count_q;
         endcase
      end
   end

   // R4: occupancy never exceeds the depth
   a_r4_never_over: assert property (@(posedge clk) disable iff (!rst_n)
      count_q <= CW'(DEPTH));

   // R4: a push into a full queue without a pop is dropped
   a_r4_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop && full && !clr) |=> (count_q == CW'(DEPTH)));

   // R3: a clear empties the queue
   a_r3_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (count_q == '0));
endmodule

// File: rtl/spim_shifter.sv
`timescale 1ns/1ps
module spim_shifter #(
   parameter int DIV_W  = 8,
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              cpol,
   input  logic              cpha,
   input  logic              msb_first,
   input  logic              wide,
   input  logic [DIV_W-1:0]  div,
   input  logic              tx_valid,
   input  logic [WORD_W-1:0] tx_word,
   output logic              tx_pop,
   output logic              rx_push,
   output logic [WORD_W-1:0] rx_word,
   output logic              busy,
   output logic              sck,
   output logic              mosi,
   input  logic              miso
);
   localparam int BIT_W = $clog2(WORD_W);
   localparam int HALF  = WORD_W / 2;

   logic              busy_q, lvl_q, first_q;
   logic [DIV_W-1:0]  cnt_q, half;
   logic [BIT_W-1:0]  bit_q, last_bit;
   logic [WORD_W-1:0] tx_sr, rx_sr, tx_shift, rx_in, rx_full;
   logic [DIV_W:0]    period;
   logic              lead, trail, done;

   assign period   = {1'b0, div} + 1'b1;
   assign half     = period[DIV_W:1];
   assign lead     = busy_q && (cnt_q == '0);
   assign trail    = busy_q && (cnt_q == half);
   assign last_bit = wide ? BIT_W'(WORD_W - 1) : BIT_W'(HALF - 1);
   assign done     = trail && (bit_q == last_bit);

   assign tx_shift = msb_first ? (tx_sr << 1) : (tx_sr >> 1);
   assign rx_in    = msb_first ? {rx_sr[WORD_W-2:0], miso} : {miso, rx_sr[WORD_W-1:1]};
   assign rx_full  = cpha ? rx_in : rx_sr;

   always_comb begin
      if (wide)           rx_word = rx_full;
      else if (msb_first) rx_word = {{HALF{1'b0}}, rx_full[HALF-1:0]};
      else                rx_word = {{HALF{1'b0}}, rx_full[WORD_W-1:HALF]};
   end

   assign tx_pop  = en && !busy_q && tx_valid;
   assign rx_push = en && done;
   assign busy    = busy_q;
   assign sck     = cpol ^ lvl_q;
   assign mosi    = msb_first ? (wide ? tx_sr[WORD_W-1] : tx_sr[HALF-1]) : tx_sr[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         lvl_q   <= 1'b0;
         first_q <= 1'b0;
         cnt_q   <= '0;
         bit_q   <= '0;
         tx_sr   <= '0;
         rx_sr   <= '0;
      end else if (!en) begin
         busy_q <= 1'b0;
         lvl_q  <= 1'b0;
      end else if (!busy_q) begin
         if (tx_valid) begin
            busy_q  <= 1'b1;
            cnt_q   <= '0;
            bit_q   <= '0;
            first_q <= 1'b1;
            tx_sr   <= tx_word;
            rx_sr   <= '0;
         end
      end else begin
         cnt_q <= (cnt_q == div) ? '0 : cnt_q + 1'b1;
         if (lead) begin
            lvl_q   <= 1'b1;
            first_q <= 1'b0;
            if (!cpha)        rx_sr <= rx_in;
            else if (!first_q) tx_sr <= tx_shift;
         end
         if (trail) begin
            lvl_q <= 1'b0;
            if (!cpha) tx_sr <= tx_shift;
            else       rx_sr <= rx_in;
            bit_q <= bit_q + 1'b1;
            if (done) busy_q <= 1'b0;
         end
      end
   end

   // R12: leaving run mode stops the engine and parks the clock
   a_r12_abort_stops: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!busy_q && (sck == cpol)));

   // R7: the divider counter stays inside one serial period
   a_r7_cnt_in_period: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (cnt_q <= div));

   // R8: sck rests at the polarity level between words
   a_r8_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q |-> (sck == cpol));

   // R13: taking a word from the queue starts a transfer
   a_r13_pop_starts: assert property (@(posedge clk) disable iff (!rst_n)
      tx_pop |=> busy_q);
endmodule

// File: rtl/spi_fifo_master.sv
`timescale 1ns/1ps
module spi_fifo_master #(
   parameter int FIFO_DEPTH = 4,
   parameter int DIV_W      = 8
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [4:0]  reg_addr,
   input  logic        reg_wr,
   input  logic [31:0] reg_wdata,
   input  logic        reg_rd,
   output logic [31:0] reg_rdata,
   output logic        sck,
   output logic        mosi,
   input  logic        miso,
   output logic        irq
);
   import spim_pkg::*;

   localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
   localparam logic [DIV_W-1:0] DIV_MAX = '1;

   initial begin : elab_chk
      a_depth_range: assert (FIFO_DEPTH >= 2 && FIFO_DEPTH <= 7)
         else $error("FIFO_DEPTH must fit the 3-bit status count");
      a_div_range: assert (DIV_W >= 2 && DIV_W <= 8)
         else $error("DIV_W must fit the 8-bit divider field");
   end

   spim_mode_e       mode_q;
   logic             cpol_q, cpha_q, msbf_q, rxie_q, wide_q;
   logic [1:0]       thr_q;
   logic [DIV_W-1:0] div_q, div_new;
   logic             wr_mode, wr_c0, wr_c1, wr_data, rd_data, is_cfg, clr;
   logic             tx_pop, tx_empty, rx_push, rx_empty, busy, rx_th;
   logic [15:0]      tx_word, rx_word, rx_head;
   logic [CNT_W-1:0] tx_cnt, rx_cnt;
   logic [7:0]       div_fld;
   logic [31:0]      stat;
   logic             unused_wdata;

   assign unused_wdata = ^reg_wdata[31:16];

   assign wr_mode = reg_wr && (reg_addr == A_MODE);
   assign wr_c0   = reg_wr && (reg_addr == A_CTL0);
   assign wr_c1   = reg_wr && (reg_addr == A_CTL1);
   assign wr_data = reg_wr && (reg_addr == A_DATA);
   assign rd_data = reg_rd && (reg_addr == A_DATA);
   assign is_cfg  = (mode_q == MODE_CFG);
   assign clr     = wr_mode && reg_wdata[0];
   assign div_fld = reg_wdata[15:8];

   always_comb begin
      if (div_fld == 8'd0)                 div_new = DIV_W'(1);
      else if ({24'd0, div_fld} > 32'(DIV_MAX)) div_new = DIV_MAX;
      else                                 div_new = div_fld[DIV_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_CFG;
         cpol_q <= 1'b0;
         cpha_q <= 1'b0;
         msbf_q <= 1'b0;
         rxie_q <= 1'b0;
         thr_q  <= 2'd0;
         wide_q <= 1'b0;
         div_q  <= DIV_W'(1);
      end else begin
         if (wr_mode && (reg_wdata[7:6] == 2'b01)) mode_q <= MODE_CFG;
         if (wr_mode && (reg_wdata[7:6] == 2'b10)) mode_q <= MODE_RUN;
         if (wr_c0) begin
            thr_q  <= reg_wdata[13:12];
            rxie_q <= reg_wdata[9];
            if (is_cfg) begin
               cpol_q <= reg_wdata[0];
               cpha_q <= reg_wdata[1];
               msbf_q <= reg_wdata[2];
            end
         end
         if (wr_c1 && is_cfg) begin
            div_q  <= div_new;
            wide_q <= (reg_wdata[7:0] == 8'd16);
         end
      end
   end

   spim_fifo #(.W(16), .DEPTH(FIFO_DEPTH)) i_tx_fifo (
      .clk(clk), .rst_n(rst_n), .clr(clr),
      .push(wr_data), .din(reg_wdata[15:0]),
      .pop(tx_pop), .dout(tx_word),
      .count(tx_cnt), .empty(tx_empty)
   );

   spim_fifo #(.W(16), .DEPTH(FIFO_DEPTH)) i_rx_fifo (
      .clk(clk), .rst_n(rst_n), .clr(clr),
      .push(rx_push), .din(rx_word),
      .pop(rd_data), .dout(rx_head),
      .count(rx_cnt), .empty(rx_empty)
   );

   spim_shifter #(.DIV_W(DIV_W), .WORD_W(16)) i_shifter (
      .clk(clk), .rst_n(rst_n), .en(mode_q == MODE_RUN),
      .cpol(cpol_q), .cpha(cpha_q), .msb_first(msbf_q), .wide(wide_q),
      .div(div_q), .tx_valid(!tx_empty), .tx_word(tx_word), .tx_pop(tx_pop),
      .rx_push(rx_push), .rx_word(rx_word), .busy(busy),
      .sck(sck), .mosi(mosi), .miso(miso)
   );

   assign rx_th = ({{(32-CNT_W){1'b0}}, rx_cnt} >= ({30'd0, thr_q} + 32'd1));
   assign irq   = rx_th && rxie_q;

   always_comb begin
      stat        = '0;
      stat[14]    = rx_th;
      stat[13:11] = 3'(tx_cnt);
      stat[10:8]  = 3'(rx_cnt);
      stat[2]     = !busy && tx_empty;
   end

   always_comb begin
      case (reg_addr)
         A_MODE:  reg_rdata = {24'd0, mode_q, 6'd0};
         A_CTL0:  reg_rdata = {18'd0, thr_q, 2'd0, rxie_q, 6'd0, msbf_q, cpha_q, cpol_q};
         A_CTL1:  reg_rdata = {16'd0, 8'(div_q), wide_q ? 8'd16 : 8'd8};
         A_STAT:  reg_rdata = stat;
         A_DATA:  reg_rdata = rx_empty ? 32'd0 : {16'd0, rx_head};
         default: reg_rdata = 32'd0;
      endcase
   end

   // R5: control 1 cannot change while running
   a_r5_ctl1_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_c1 && (mode_q == MODE_RUN)) |=> ($stable(div_q) && $stable(wide_q)));

   // R11: the interrupt never fires with an empty receive queue
   a_r11_irq_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> !rx_empty);
endmodule

// File: tb/test_spi_fifo_master.sv
`timescale 1ns/1ps
module test_spi_fifo_master;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  reg_addr = 5'd0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = 32'd0;
   logic        reg_rd = 1'b0;
   logic [31:0] reg_rdata;
   logic        sck, mosi, miso, irq;

   always #2 clk = ~clk;
   assign miso = mosi;

   spi_fifo_master i_spi_fifo_master (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
      .sck(sck), .mosi(mosi), .miso(miso), .irq(irq)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic [15:0] exp_q[$];
   logic [15:0] rx_q[$];

   bit   mon_en = 1'b0;
   logic m_cpol = 1'b0, m_cpha = 1'b0, m_msb = 1'b0, m_wide = 1'b0;
   int   m_div = 1;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_rd = 1'b1;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   // slave model and scoreboard monitor
   logic       prev_sck = 1'b0;
   int         bits = 0, leads = 0, cyc = 0;
   logic [15:0] acc = 16'd0;
   always @(negedge clk) begin
      if (!mon_en) begin
         bits = 0; leads = 0; cyc = 0; acc = 16'd0; prev_sck = sck;
      end else begin
         logic le, te, smp;
         logic [15:0] e;
         int wbits;
         wbits = m_wide ? 16 : 8;
         cyc++;
         le = (prev_sck == m_cpol) && (sck != m_cpol);
         te = (prev_sck != m_cpol) && (sck == m_cpol);
         if (le) begin
            if (leads > 0) chk(cyc == m_div + 1, "R7 sck period", cyc, m_div + 1);
            leads++;
            cyc = 0;
         end
         smp = m_cpha ? te : le;
         if (smp) begin
            if (m_msb) acc = {acc[14:0], mosi};
            else       acc[bits] = mosi;
            bits++;
            if (bits == wbits) begin
               if (exp_q.size() == 0) begin
                  chk(1'b0, "R9 unexpected serial word", {16'd0, acc}, 32'd0);
               end else begin
                  e = exp_q.pop_front();
                  chk(acc == e, "R9/R8 serial word", {16'd0, acc}, {16'd0, e});
               end
               bits = 0; leads = 0; acc = 16'd0;
            end
         end
         prev_sck = sck;
      end
   end

   task automatic cfg(input logic cp, input logic ph, input logic msb, input logic wd, input int dv);
      mon_en = 1'b0;
      wr(5'h00, 32'h40);
      wr(5'h04, {29'd0, msb, ph, cp});
      wr(5'h08, {16'd0, 8'(dv), wd ? 8'd16 : 8'd8});
      m_cpol = cp; m_cpha = ph; m_msb = msb; m_wide = wd; m_div = dv;
      wr(5'h00, 32'h80);
      @(negedge clk);
      mon_en = 1'b1;
   endtask

   task automatic push_word(input logic [15:0] w);
      logic [15:0] m;
      m = m_wide ? w : {8'd0, w[7:0]};
      exp_q.push_back(m);
      rx_q.push_back(m);
      wr(5'h18, {16'd0, w});
   endtask

   task automatic wait_idle();
      logic [31:0] s;
      for (int i = 0; i < 20000; i++) begin
         rd(5'h14, s);
         if (s[2]) break;
      end
   endtask

   task automatic drain(input int n);
      logic [31:0] d;
      logic [15:0] e;
      for (int i = 0; i < n; i++) begin
         rd(5'h18, d);
         e = rx_q.pop_front();
         chk(d == {16'd0, e}, "R13 loopback word", d, {16'd0, e});
      end
      chk(sck == m_cpol, "R8 idle level", {31'd0, sck}, {31'd0, m_cpol});
   endtask

   task automatic scenario(input logic cp, input logic ph, input logic msb, input logic wd,
                           input int dv, input int n, input logic [15:0] seed);
      cfg(cp, ph, msb, wd, dv);
      for (int i = 0; i < n; i++) push_word(seed ^ 16'(i * 16'h3C5A));
      wait_idle();
      chk(exp_q.size() == 0, "R13 all words sent", exp_q.size(), 0);
      drain(n);
   endtask

   initial begin
      logic [31:0] d;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(5'h00, d); chk(d == 32'h40, "R1 mode reset", d, 32'h40);
      rd(5'h04, d); chk(d == 32'h0, "R1 ctl0 reset", d, 32'h0);
      rd(5'h08, d); chk(d == 32'h0108, "R1 ctl1 reset", d, 32'h0108);
      rd(5'h14, d); chk(d == 32'h0004, "R1 status reset", d, 32'h0004);
      chk(irq == 1'b0, "R1 irq reset", {31'd0, irq}, 32'd0);
      chk(sck == 1'b0, "R1 sck reset", {31'd0, sck}, 32'd0);

      // R2 mode field
      wr(5'h00, 32'hC0); rd(5'h00, d); chk(d == 32'h40, "R2 mode 11 ignored", d, 32'h40);
      wr(5'h00, 32'h80); rd(5'h00, d); chk(d == 32'h80, "R2 run mode", d, 32'h80);
      wr(5'h00, 32'h00); rd(5'h00, d); chk(d == 32'h80, "R2 mode 00 ignored", d, 32'h80);
      wr(5'h00, 32'h40); rd(5'h00, d); chk(d == 32'h40, "R2 cfg mode", d, 32'h40);

      // R5 locking of format fields
      wr(5'h08, 32'h0308); rd(5'h08, d); chk(d == 32'h0308, "R5 ctl1 write in cfg", d, 32'h0308);
      wr(5'h00, 32'h80);
      wr(5'h08, 32'h0710); rd(5'h08, d); chk(d == 32'h0308, "R5 ctl1 locked in run", d, 32'h0308);
      wr(5'h04, 32'h3207); rd(5'h04, d); chk(d == 32'h3200, "R5 ctl0 low bits locked", d, 32'h3200);
      wr(5'h00, 32'h40);
      wr(5'h04, 32'h0000);

      // R6 word length, R7 divider clamp
      wr(5'h08, 32'h020C); rd(5'h08, d); chk(d == 32'h0208, "R6 odd length reads 8", d, 32'h0208);
      wr(5'h08, 32'h0010); rd(5'h08, d); chk(d == 32'h0110, "R7 divider 0 stored as 1", d, 32'h0110);

      // R4 / R3 queue depth, empty read, clear
      for (int i = 0; i < 5; i++) wr(5'h18, 32'(16'h1000 + i));
      rd(5'h14, d); chk(d == 32'h2000, "R4 tx queue full at 4", d, 32'h2000);
      rd(5'h18, d); chk(d == 32'h0, "R4 empty read returns 0", d, 32'h0);
      wr(5'h00, 32'h41);
      rd(5'h14, d); chk(d == 32'h0004, "R3 clear empties queues", d, 32'h0004);
      rd(5'h00, d); chk(d == 32'h40, "R3 mode kept by clear", d, 32'h40);

      // R8 R9 R7 R13 transfers in all clock and order modes
      scenario(1'b0, 1'b0, 1'b1, 1'b0, 1,   4, 16'h00A7);
      scenario(1'b1, 1'b0, 1'b1, 1'b1, 2,   3, 16'hC3E1);
      scenario(1'b0, 1'b1, 1'b0, 1'b0, 3,   4, 16'h0059);
      scenario(1'b1, 1'b1, 1'b0, 1'b1, 4,   2, 16'h8421);
      scenario(1'b0, 1'b1, 1'b1, 1'b1, 255, 1, 16'hB00D);

      // R10 R11 threshold and interrupt
      cfg(1'b0, 1'b0, 1'b1, 1'b0, 1);
      wr(5'h04, 32'h1204);
      push_word(16'h0033);
      wait_idle();
      rd(5'h14, d); chk(d == 32'h0104, "R10 status one word", d, 32'h0104);
      chk(irq == 1'b0, "R11 irq below threshold", {31'd0, irq}, 32'd0);
      push_word(16'h00CC);
      wait_idle();
      rd(5'h14, d); chk(d == 32'h4204, "R10 threshold flag", d, 32'h4204);
      chk(irq == 1'b1, "R11 irq at threshold", {31'd0, irq}, 32'd1);
      wr(5'h04, 32'h1004);
      chk(irq == 1'b0, "R11 irq masked by enable", {31'd0, irq}, 32'd0);
      wr(5'h04, 32'h1204);
      drain(1);
      chk(irq == 1'b0, "R11 irq drops after pop", {31'd0, irq}, 32'd0);
      drain(1);

      // R12 abandon a word in flight
      cfg(1'b0, 1'b0, 1'b1, 1'b1, 255);
      mon_en = 1'b0;
      wr(5'h18, 32'hA5A5);
      wr(5'h18, 32'h5A5A);
      repeat (600) @(negedge clk);
      chk(sck == 1'b1, "R12 word in flight", {31'd0, sck}, 32'd1);
      wr(5'h00, 32'h40);
      repeat (2) @(negedge clk);
      chk(sck == 1'b0, "R12 sck parked", {31'd0, sck}, 32'd0);
      rd(5'h14, d); chk(d == 32'h0800, "R12 queued word kept, none received", d, 32'h0800);
      repeat (300) @(negedge clk);
      chk(sck == 1'b0, "R12 sck stays idle", {31'd0, sck}, 32'd0);
      wr(5'h00, 32'h41);
      rd(5'h14, d); chk(d == 32'h0004, "R3 clear after abort", d, 32'h0004);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end
endmodule